// File: doc/BRIEF.md
# Gated Echo Threshold Alarm

This block watches several channels of filtered, envelope-detected ultrasonic echo samples in parallel and raises two kinds of alarm per channel within the same transmit frame. There is no processor polling. Each channel has two time gates, and every gate is placed by a start sample index and a width, both counted from a frame-start pulse.

- The over-level gate (gate A) trips as soon as an echo sample inside its window rises above its threshold. This points to a large reflector in the workpiece.
- The under-level gate (gate B) trips when its window closes without the echo ever reaching its threshold. This points to lost coupling or a faulty signal path.

Each gate also reports the largest sample it has seen in the current frame. Alarm flags hold for the rest of the frame and are released at the next frame start. In latch mode they hold until an explicit clear.

One sample index counter is shared by all channels. It restarts at every frame start, and it stops at its top value so that a window can never open a second time within a frame.

Top module: `echo_gate_alarm`

## Requirements
- R1: While reset is low, and in the cycle after reset, every peak output and every alarm flag is 0.
- R2: A sample counts only when `sample_vld` is high, a frame has started since reset, and `frame_start` is low. The first counted sample after a `frame_start` has index 0, and each further counted sample adds 1. Samples before the first `frame_start` are ignored.
- R3: Each gate's peak output (channel c at bits c*SW upward) is the largest counted sample whose index lies in [start, start+width-1]. It is visible in the cycle after that sample and is cleared to 0 in the cycle after `frame_start`.
- R4: `alarm_a[c]` becomes 1 in the cycle after a counted in-window sample that is strictly greater than the gate A threshold. A sample equal to the threshold does not trip it.
- R5: In the cycle after the counted sample with index start+width-1 of gate B, `alarm_b[c]` becomes 1 if the largest in-window sample, including that one, is below the gate B threshold. Reaching the threshold exactly prevents the alarm. A window that has not completed raises nothing.
- R6: A gate whose enable bit is 0, or whose width is 0, never raises its alarm and keeps its peak at 0.
- R7: With `latch_mode` at 0, a raised alarm stays at 1 through the frame and returns to 0 in the cycle after the next `frame_start`.
- R8: With `latch_mode` at 1, `frame_start` leaves the alarm flags unchanged.
- R9: `alarm_clr` clears both alarms of every channel in the next cycle. A trip in the same cycle wins over the clear.
- R10: The index counter stops at 2^IW-1. Samples arriving after that index are ignored until the next `frame_start`, so a window reaching past it never completes.
- R11: Channels are independent: each uses only its own samples and its own gate settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at each transmit; carries no sample |
| sample_vld | input | 1 | Samples on all channels are valid this cycle |
| samples | input | NCH*SW | Echo amplitude per channel, channel c at bits c*SW |
| latch_mode | input | 1 | 1: alarms survive frame starts until cleared |
| alarm_clr | input | 1 | Clear all alarm flags |
| a_en | input | NCH | Gate A enable per channel |
| a_start | input | NCH*IW | Gate A first index per channel |
| a_width | input | NCH*IW | Gate A length in samples per channel |
| a_thr | input | NCH*SW | Gate A over-level threshold per channel |
| b_en | input | NCH | Gate B enable per channel |
| b_start | input | NCH*IW | Gate B first index per channel |
| b_width | input | NCH*IW | Gate B length in samples per channel |
| b_thr | input | NCH*SW | Gate B required level per channel |
| peak_a | output | NCH*SW | Largest gate A sample this frame per channel |
| peak_b | output | NCH*SW | Largest gate B sample this frame per channel |
| alarm_a | output | NCH | Over-level alarm per channel |
| alarm_b | output | NCH | Lost-echo alarm per channel |

## Verification
The bench builds the block with eight channels and 10-bit samples, but with a 6-bit index width. This limits a frame to 64 counted samples, so the saturating counter and windows that run past the last index are reached in short frames. Random gate placements inside that 64-sample range regularly produce windows that overlap, touch index 0, or close on the very last sample. Thresholds set inside the sample range make exact-equality cases occur in both gates.

// File: rtl/egate_pkg.sv
// Package: shared types for the gated echo alarm.
// Assumes: nothing beyond the standard language.
package egate_pkg;
    // Sense of a gate: trip above the level, or trip when the level is never reached.
    typedef enum logic {
        GATE_OVER  = 1'b0,
        GATE_UNDER = 1'b1
    } gate_kind_e;
endpackage

// File: rtl/egate_index.sv
// Module: shared sample index counter.
// Counts valid samples from each frame start and stops at its top value.
// Assumes frame_start carries no sample and that samples before the
// first frame start after reset are meaningless.
module egate_index #(
    parameter int IW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          sample_vld,
    output logic [IW-1:0] idx,
    output logic          samp_ok
);
    localparam logic [IW-1:0] IDX_TOP = '1;

    logic armed;
    logic spent;

    // A sample counts only inside a started, not yet exhausted frame.
    assign samp_ok = sample_vld && armed && !spent && !frame_start;

    // Restart on frame start, advance per counted sample, stop at the top index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx   <= '0;
            armed <= 1'b0;
            spent <= 1'b0;
        end else if (frame_start) begin
            idx   <= '0;
            armed <= 1'b1;
            spent <= 1'b0;
        end else if (samp_ok) begin
            if (idx == IDX_TOP) begin
                spent <= 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/egate_window.sv
// Module: one time gate with peak capture and a sticky alarm.
// KIND picks the over-level or the lost-echo decision.
// Assumes samp_ok/idx come from egate_index; a trip wins over any clear.
module egate_window
    import egate_pkg::*;
#(
    parameter int         SW   = 10,
    parameter int         IW   = 12,
    parameter gate_kind_e KIND = GATE_OVER
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          samp_ok,
    input  logic [IW-1:0] idx,
    input  logic [SW-1:0] sample,
    input  logic          en,
    input  logic [IW-1:0] start,
    input  logic [IW-1:0] width,
    input  logic [SW-1:0] thr,
    input  logic          latch_mode,
    input  logic          alarm_clr,
    output logic [SW-1:0] peak,
    output logic          alarm
);
    localparam int EW = IW + 1;

    logic [EW-1:0] win_end;
    logic [EW-1:0] idx_x;
    logic          in_win;
    logic          last_idx;
    logic [SW-1:0] peak_nxt;
    logic          trip;

    // Window bounds widened by one bit so start+width cannot wrap.
    assign win_end  = {1'b0, start} + {1'b0, width};
    assign idx_x    = {1'b0, idx};
    assign in_win   = samp_ok && en && (width != '0)
                      && (idx_x >= {1'b0, start}) && (idx_x < win_end);
    assign last_idx = in_win && ((idx_x + EW'(1)) == win_end);

    // Running maximum including the current sample.
    assign peak_nxt = (in_win && (sample > peak)) ? sample : peak;

    // Decision logic selected by the gate sense.
    generate
        if (KIND == GATE_OVER) begin : g_over
            assign trip = in_win && (sample > thr);
        end else begin : g_under
            assign trip = last_idx && (peak_nxt < thr);
        end
    endgenerate

    // Peak register: cleared per frame, follows the running maximum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak <= '0;
        end else if (frame_start) begin
            peak <= '0;
        end else begin
            peak <= peak_nxt;
        end
    end

    // Alarm flag: set by a trip, released by clear or by a non-latched frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm <= 1'b0;
        end else if (trip) begin
            alarm <= 1'b1;
        end else if (alarm_clr || (frame_start && !latch_mode)) begin
            alarm <= 1'b0;
        end
    end
endmodule

// File: rtl/egate_channel.sv
// Module: one echo channel holding an over-level gate and a lost-echo gate.
// Assumes the shared index and sample qualifier from egate_index.
module egate_channel
    import egate_pkg::*;
#(
    parameter int SW = 10,
    parameter int IW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          samp_ok,
    input  logic [IW-1:0] idx,
    input  logic [SW-1:0] sample,
    input  logic          latch_mode,
    input  logic          alarm_clr,
    input  logic          a_en,
    input  logic [IW-1:0] a_start,
    input  logic [IW-1:0] a_width,
    input  logic [SW-1:0] a_thr,
    input  logic          b_en,
    input  logic [IW-1:0] b_start,
    input  logic [IW-1:0] b_width,
    input  logic [SW-1:0] b_thr,
    output logic [SW-1:0] peak_a,
    output logic [SW-1:0] peak_b,
    output logic          alarm_a,
    output logic          alarm_b
);
    egate_window #(.SW(SW), .IW(IW), .KIND(GATE_OVER)) i_gate_a (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .samp_ok(samp_ok), .idx(idx), .sample(sample),
        .en(a_en), .start(a_start), .width(a_width), .thr(a_thr),
        .latch_mode(latch_mode), .alarm_clr(alarm_clr),
        .peak(peak_a), .alarm(alarm_a)
    );

    egate_window #(.SW(SW), .IW(IW), .KIND(GATE_UNDER)) i_gate_b (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .samp_ok(samp_ok), .idx(idx), .sample(sample),
        .en(b_en), .start(b_start), .width(b_width), .thr(b_thr),
        .latch_mode(latch_mode), .alarm_clr(alarm_clr),
        .peak(peak_b), .alarm(alarm_b)
    );
endmodule

// File: rtl/echo_gate_alarm.sv
// Module: multi-channel gated echo threshold alarm (top).
// Runs NCH channels in parallel from one shared sample index counter.
// Assumes all channels are sampled together under one sample_vld.
module echo_gate_alarm #(
    parameter int NCH = 8,
    parameter int SW  = 10,
    parameter int IW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              sample_vld,
    input  logic [NCH*SW-1:0] samples,
    input  logic              latch_mode,
    input  logic              alarm_clr,
    input  logic [NCH-1:0]    a_en,
    input  logic [NCH*IW-1:0] a_start,
    input  logic [NCH*IW-1:0] a_width,
    input  logic [NCH*SW-1:0] a_thr,
    input  logic [NCH-1:0]    b_en,
    input  logic [NCH*IW-1:0] b_start,
    input  logic [NCH*IW-1:0] b_width,
    input  logic [NCH*SW-1:0] b_thr,
    output logic [NCH*SW-1:0] peak_a,
    output logic [NCH*SW-1:0] peak_b,
    output logic [NCH-1:0]    alarm_a,
    output logic [NCH-1:0]    alarm_b
);
    logic [IW-1:0] idx;
    logic          samp_ok;

    egate_index #(.IW(IW)) i_index (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .sample_vld(sample_vld), .idx(idx), .samp_ok(samp_ok)
    );

    // One channel slice per echo channel.
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            egate_channel #(.SW(SW), .IW(IW)) i_channel (
                .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
                .samp_ok(samp_ok), .idx(idx),
                .sample(samples[c*SW +: SW]),
                .latch_mode(latch_mode), .alarm_clr(alarm_clr),
                .a_en(a_en[c]), .a_start(a_start[c*IW +: IW]),
                .a_width(a_width[c*IW +: IW]), .a_thr(a_thr[c*SW +: SW]),
                .b_en(b_en[c]), .b_start(b_start[c*IW +: IW]),
                .b_width(b_width[c*IW +: IW]), .b_thr(b_thr[c*SW +: SW]),
                .peak_a(peak_a[c*SW +: SW]), .peak_b(peak_b[c*SW +: SW]),
                .alarm_a(alarm_a[c]), .alarm_b(alarm_b[c])
            );
        end
    endgenerate
endmodule

// File: rtl/echo_gate_alarm_chk.sv
// Checker: temporal properties of echo_gate_alarm, bound to every instance.
module echo_gate_alarm_chk #(
    parameter int NCH = 8,
    parameter int SW  = 10,
    parameter int IW  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic              sample_vld,
    input logic              latch_mode,
    input logic              alarm_clr,
    input logic [NCH-1:0]    a_en,
    input logic [NCH-1:0]    b_en,
    input logic [NCH*SW-1:0] peak_a,
    input logic [NCH*SW-1:0] peak_b,
    input logic [NCH-1:0]    alarm_a,
    input logic [NCH-1:0]    alarm_b
);
    // R1: a reset cycle leaves every output at zero.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (alarm_a == '0 && alarm_b == '0 && peak_a == '0 && peak_b == '0));

    // R3: peaks are empty right after a frame start.
    a_r3_peak_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (peak_a == '0 && peak_b == '0));

    // R9: a clear with no sample present empties all alarms.
    a_r9_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_clr && !sample_vld) |=> (alarm_a == '0 && alarm_b == '0));

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            // R4: an over-level alarm rises only after a valid sample.
            a_r4_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(alarm_a[c]) |-> $past(sample_vld));

            // R6: a disabled gate A cannot raise its alarm.
            a_r6_a_disabled: assert property (@(posedge clk) disable iff (!rst_n)
                !a_en[c] |=> !$rose(alarm_a[c]));

            // R6: a disabled gate B cannot raise its alarm.
            a_r6_b_disabled: assert property (@(posedge clk) disable iff (!rst_n)
                !b_en[c] |=> !$rose(alarm_b[c]));

            // R8: latched alarms survive anything but a clear.
            a_r8_latch_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
                (latch_mode && !alarm_clr && alarm_a[c]) |=> alarm_a[c]);

            a_r8_latch_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
                (latch_mode && !alarm_clr && alarm_b[c]) |=> alarm_b[c]);

            // R7: without latch mode, alarms do not outlive a frame start.
            a_r7_frame_release: assert property (@(posedge clk) disable iff (!rst_n)
                (frame_start && !latch_mode) |=> (!alarm_a[c] && !alarm_b[c]));
        end
    endgenerate
endmodule

bind echo_gate_alarm echo_gate_alarm_chk #(.NCH(NCH), .SW(SW), .IW(IW)) i_echo_gate_alarm_chk (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sample_vld(sample_vld),
    .latch_mode(latch_mode), .alarm_clr(alarm_clr), .a_en(a_en), .b_en(b_en),
    .peak_a(peak_a), .peak_b(peak_b), .alarm_a(alarm_a), .alarm_b(alarm_b)
);

// File: tb/test_echo_gate_alarm.sv
module test_echo_gate_alarm;
    localparam int NCH  = 8;
    localparam int SW   = 10;
    localparam int IW   = 6;
    localparam int ITOP = (1 << IW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              frame_start = 1'b0;
    logic              sample_vld = 1'b0;
    logic [NCH*SW-1:0] samples = '0;
    logic              latch_mode = 1'b0;
    logic              alarm_clr = 1'b0;
    logic [NCH-1:0]    a_en = '0;
    logic [NCH*IW-1:0] a_start = '0;
    logic [NCH*IW-1:0] a_width = '0;
    logic [NCH*SW-1:0] a_thr = '0;
    logic [NCH-1:0]    b_en = '0;
    logic [NCH*IW-1:0] b_start = '0;
    logic [NCH*IW-1:0] b_width = '0;
    logic [NCH*SW-1:0] b_thr = '0;
    logic [NCH*SW-1:0] peak_a;
    logic [NCH*SW-1:0] peak_b;
    logic [NCH-1:0]    alarm_a;
    logic [NCH-1:0]    alarm_b;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Bench-side expected state.
    int  m_idx = 0;
    bit  m_armed = 0;
    bit  m_spent = 0;
    int  m_pa[NCH];
    int  m_pb[NCH];
    bit  m_aa[NCH];
    bit  m_ab[NCH];

    echo_gate_alarm #(.NCH(NCH), .SW(SW), .IW(IW)) i_echo_gate_alarm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sample_vld(sample_vld),
        .samples(samples), .latch_mode(latch_mode), .alarm_clr(alarm_clr),
        .a_en(a_en), .a_start(a_start), .a_width(a_width), .a_thr(a_thr),
        .b_en(b_en), .b_start(b_start), .b_width(b_width), .b_thr(b_thr),
        .peak_a(peak_a), .peak_b(peak_b), .alarm_a(alarm_a), .alarm_b(alarm_b)
    );

    always #5ns clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pa(input int c); return int'(peak_a[c*SW +: SW]); endfunction
    function automatic int pb(input int c); return int'(peak_b[c*SW +: SW]); endfunction

    function automatic logic [NCH*SW-1:0] fill(input int v);
        logic [NCH*SW-1:0] r;
        for (int c = 0; c < NCH; c++) r[c*SW +: SW] = SW'(v);
        return r;
    endfunction

    // Advance the expected state by one clock using the inputs now applied.
    task automatic model_step();
        bit ok;
        ok = sample_vld && m_armed && !m_spent && !frame_start;
        for (int c = 0; c < NCH; c++) begin
            int s, as_, aw, at, bs, bw, bt, pk;
            bit in_a, in_b, trip_a, trip_b;
            s   = int'(samples[c*SW +: SW]);
            as_ = int'(a_start[c*IW +: IW]); aw = int'(a_width[c*IW +: IW]); at = int'(a_thr[c*SW +: SW]);
            bs  = int'(b_start[c*IW +: IW]); bw = int'(b_width[c*IW +: IW]); bt = int'(b_thr[c*SW +: SW]);
            in_a = ok && a_en[c] && aw != 0 && m_idx >= as_ && m_idx < as_ + aw;
            in_b = ok && b_en[c] && bw != 0 && m_idx >= bs && m_idx < bs + bw;
            trip_a = in_a && s > at;
            pk = (in_b && s > m_pb[c]) ? s : m_pb[c];
            trip_b = in_b && (m_idx == bs + bw - 1) && pk < bt;
            if (!rst_n) begin
                m_pa[c] = 0; m_pb[c] = 0; m_aa[c] = 0; m_ab[c] = 0;
            end else begin
                if (frame_start) begin
                    m_pa[c] = 0; m_pb[c] = 0;
                end else begin
                    if (in_a && s > m_pa[c]) m_pa[c] = s;
                    m_pb[c] = pk;
                end
                if (trip_a) m_aa[c] = 1;
                else if (alarm_clr || (frame_start && !latch_mode)) m_aa[c] = 0;
                if (trip_b) m_ab[c] = 1;
                else if (alarm_clr || (frame_start && !latch_mode)) m_ab[c] = 0;
            end
        end
        if (!rst_n) begin
            m_idx = 0; m_armed = 0; m_spent = 0;
        end else if (frame_start) begin
            m_idx = 0; m_armed = 1; m_spent = 0;
        end else if (ok) begin
            if (m_idx == ITOP) m_spent = 1;
            else m_idx++;
        end
    endtask

    // One clock: drive at the falling edge, compare after the rising edge.
    task automatic cyc(input logic fs, input logic vld, input logic [NCH*SW-1:0] smp, input logic clr);
        @(negedge clk);
        frame_start = fs; sample_vld = vld; samples = smp; alarm_clr = clr;
        @(posedge clk);
        #1ns;
        model_step();
        for (int c = 0; c < NCH; c++) begin
            chk(pa(c) == m_pa[c], "R3 peak_a", pa(c), m_pa[c]);
            chk(pb(c) == m_pb[c], "R3 peak_b", pb(c), m_pb[c]);
            chk(alarm_a[c] == m_aa[c], "R4 alarm_a", int'(alarm_a[c]), int'(m_aa[c]));
            chk(alarm_b[c] == m_ab[c], "R5 alarm_b", int'(alarm_b[c]), int'(m_ab[c]));
        end
    endtask

    task automatic set_all(input int as_, input int aw, input int at, input int bs, input int bw, input int bt);
        for (int c = 0; c < NCH; c++) begin
            a_start[c*IW +: IW] = IW'(as_); a_width[c*IW +: IW] = IW'(aw); a_thr[c*SW +: SW] = SW'(at);
            b_start[c*IW +: IW] = IW'(bs);  b_width[c*IW +: IW] = IW'(bw); b_thr[c*SW +: SW] = SW'(bt);
        end
        a_en = '1; b_en = '1;
    endtask

    // Gate A over-level on idx 5..7 at 500, gate B needs 300 on idx 2..3.
    task automatic std_frame(input int v5, input logic clr5);
        cyc(1, 0, '0, 0);
        cyc(0, 1, fill(10), 0);
        cyc(0, 1, fill(10), 0);
        cyc(0, 1, fill(400), 0);
        cyc(0, 1, fill(400), 0);
        cyc(0, 1, fill(10), 0);
        cyc(0, 1, fill(v5), clr5);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < NCH; c++) begin m_pa[c] = 0; m_pb[c] = 0; m_aa[c] = 0; m_ab[c] = 0; end

        // R1: outputs during and just after reset.
        set_all(0, 4, 100, 0, 4, 100);
        repeat (3) cyc(0, 1, fill(900), 0);
        chk(peak_a == '0 && alarm_a == '0 && alarm_b == '0, "R1 reset state", int'(alarm_a), 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: samples before the first frame start are ignored.
        repeat (3) cyc(0, 1, fill(900), 0);
        chk(pa(0) == 0, "R2 pre-frame sample ignored", pa(0), 0);
        chk(alarm_a[0] == 1'b0, "R2 pre-frame no alarm", int'(alarm_a[0]), 0);

        // Directed windows: A idx 5..7 thr 500, B idx 2..3 thr 300.
        set_all(5, 3, 500, 2, 2, 300);
        cyc(1, 0, '0, 0);
        cyc(0, 1, fill(10), 0);   // idx0
        cyc(0, 1, fill(10), 0);   // idx1
        cyc(0, 1, fill(299), 0);  // idx2
        chk(alarm_b[0] == 1'b0, "R5 no decision before window end", int'(alarm_b[0]), 0);
        cyc(0, 1, fill(299), 0);  // idx3
        chk(alarm_b[0] == 1'b1, "R5 lost echo at window end", int'(alarm_b[0]), 1);
        cyc(0, 1, fill(600), 0);  // idx4, outside A
        chk(alarm_a[0] == 1'b0, "R4 outside window ignored", int'(alarm_a[0]), 0);
        cyc(0, 1, fill(500), 0);  // idx5, equal to threshold
        chk(alarm_a[0] == 1'b0, "R4 equal does not trip", int'(alarm_a[0]), 0);
        chk(pa(0) == 500, "R3 peak first in-window", pa(0), 500);
        cyc(0, 1, fill(501), 0);  // idx6
        chk(alarm_a[0] == 1'b1, "R4 above threshold trips", int'(alarm_a[0]), 1);
        cyc(0, 1, fill(20), 0);   // idx7
        cyc(0, 1, fill(800), 0);  // idx8, past window
        chk(pa(0) == 501, "R3 peak stops at window end", pa(0), 501);
        cyc(1, 0, '0, 0);
        chk(alarm_a[0] == 1'b0 && alarm_b[0] == 1'b0, "R7 frame start releases", int'(alarm_a[0]), 0);
        chk(pa(0) == 0 && pb(0) == 0, "R3 peaks cleared at frame", pa(0), 0);
        cyc(0, 1, fill(10), 0);
        cyc(0, 1, fill(10), 0);
        cyc(0, 1, fill(300), 0);
        cyc(0, 1, fill(0), 0);
        chk(alarm_b[0] == 1'b0, "R5 reaching level prevents alarm", int'(alarm_b[0]), 0);

        // R8 latch, R9 clear.
        latch_mode = 1'b1;
        std_frame(900, 0);
        chk(alarm_a[0] == 1'b1, "R8 trip in latch mode", int'(alarm_a[0]), 1);
        cyc(1, 0, '0, 0);
        chk(alarm_a[0] == 1'b1, "R8 latched across frame start", int'(alarm_a[0]), 1);
        cyc(0, 0, '0, 1);
        chk(alarm_a == '0, "R9 clear empties alarms", int'(alarm_a), 0);
        std_frame(900, 1);
        chk(alarm_a[0] == 1'b1, "R9 trip wins over clear", int'(alarm_a[0]), 1);
        cyc(0, 0, '0, 1);
        latch_mode = 1'b0;

        // R6 disabled and zero width, R11 independence.
        set_all(5, 3, 500, 2, 2, 300);
        a_en[1] = 1'b0; a_width[2*IW +: IW] = '0; b_en[1] = 1'b0;
        cyc(1, 0, '0, 0);
        repeat (5) cyc(0, 1, fill(10), 0);
        repeat (3) cyc(0, 1, fill(900), 0);
        chk(alarm_a[1] == 1'b0 && pa(1) == 0, "R6 disabled gate silent", int'(alarm_a[1]), 0);
        chk(alarm_a[2] == 1'b0 && pa(2) == 0, "R6 zero width silent", int'(alarm_a[2]), 0);
        chk(alarm_b[1] == 1'b0, "R6 disabled lost gate silent", int'(alarm_b[1]), 0);
        chk(alarm_a[0] == 1'b1 && alarm_b[0] == 1'b1, "R11 neighbour channel still trips", int'(alarm_a[0]), 1);

        // R10: window past the top index never completes.
        set_all(60, 8, 1000, 60, 8, 1023);
        cyc(1, 0, '0, 0);
        repeat (ITOP + 1) cyc(0, 1, fill(5), 0);
        repeat (6) cyc(0, 1, fill(1023), 0);
        chk(pa(0) == 5, "R10 samples after top index ignored", pa(0), 5);
        chk(alarm_a[0] == 1'b0 && alarm_b[0] == 1'b0, "R10 unfinished window raises nothing", int'(alarm_b[0]), 0);

        // Random frames checked against the expected-state model.
        for (int f = 0; f < 300; f++) begin
            for (int c = 0; c < NCH; c++) begin
                a_start[c*IW +: IW] = IW'($urandom_range(0, 45));
                a_width[c*IW +: IW] = IW'($urandom_range(0, 16));
                a_thr[c*SW +: SW]   = SW'($urandom_range(100, 900));
                b_start[c*IW +: IW] = IW'($urandom_range(0, 50));
                b_width[c*IW +: IW] = IW'($urandom_range(0, 16));
                b_thr[c*SW +: SW]   = SW'($urandom_range(50, 600));
                a_en[c] = ($urandom_range(0, 3) != 0);
                b_en[c] = ($urandom_range(0, 3) != 0);
            end
            latch_mode = ($urandom_range(0, 4) == 0);
            cyc(1, 0, '0, 0);
            for (int n = 0, lim = $urandom_range(10, 80); n < lim; n++) begin
                logic [NCH*SW-1:0] smp;
                for (int c = 0; c < NCH; c++)
                    smp[c*SW +: SW] = ($urandom_range(0, 9) == 0) ? SW'($urandom_range(0, 1023))
                                                                  : SW'($urandom_range(0, 400));
                cyc(0, ($urandom_range(0, 4) != 0), smp, ($urandom_range(0, 30) == 0));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule